// File: doc/BRIEF.md
# Conjugate-Product Differential Phase Detector

This block turns a stream of signed complex baseband samples into a stream of phase-change vectors. Each accepted sample is multiplied by the complex conjugate of the sample accepted before it. The angle of the product is the rotation between the two samples. No angle is ever formed, so a pair of samples on either side of the negative real axis gives a small vector and not a jump of nearly a full turn. The cost is four multiplies and two adds per sample, where an angle-domain differentiator needs one subtraction.

When the envelope is not constant, the parameter `NORM` selects a second variant. In that variant both parts of the product are divided by the power of the previous sample. This is done in a pipelined restoring divider that resolves one quotient bit per stage. The result is fixed point with `FRAC` fraction bits. A previous sample of zero power gives no division: the outputs are zero and a flag is raised. The block is meant to feed a frequency-control path that needs the per-sample rotation without wrap artefacts.

Top module: `dphase_conj`

## Requirements
- R1: On each output, `out_re` equals I_n·I_{n-1} + Q_n·Q_{n-1} of the current and previous accepted samples. With `NORM=0` the value is exact at the full 25-bit signed width.
- R2: On each output, `out_im` equals Q_n·I_{n-1} − I_n·Q_{n-1}. A step from (−2047, 5) to (−2047, −5) therefore gives a small positive imaginary part, not a wrapped value.
- R3: After reset, the first accepted sample produces no output and only becomes the previous sample. A reset in the middle of a stream clears that history.
- R4: Cycles with `in_valid` low are ignored whatever `in_i` and `in_q` carry. The next accepted sample is paired with the last accepted one.
- R5: With `NORM=0`, `out_valid` rises in the cycle after the clock edge that accepts the sample, for every sample except the first.
- R6: With `NORM=1`, each part equals sign(x)·floor(|x|·2^FRAC / P), where x is the R1 or R2 value and P = I_{n-1}² + Q_{n-1}². The result arrives 1+2·W clock edges after the accepting edge, which is 25 edges by default.
- R7: When the previous sample has zero power, the output carries `zero_pwr` high together with `out_valid`, and both parts are zero, in either variant. `zero_pwr` is never high without `out_valid`.
- R8: With `NORM=1`, a quotient that would reach 2^(2W) is clamped to 2^(2W)−1 in magnitude, keeping its sign. The most negative code, −2^(2W), never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_i | input | W | In-phase sample, signed |
| in_q | input | W | Quadrature sample, signed |
| out_valid | output | 1 | Result strobe |
| out_re | output | 2W+1 | Real part of the difference vector, signed |
| out_im | output | 2W+1 | Imaginary part of the difference vector, signed |
| zero_pwr | output | 1 | Previous sample had zero power; outputs forced to zero |

## Verification
The bench tags every expected result with the cycle in which it is due. For the plain variant that is one edge after the accepting edge. For the normalised variant it is one edge for the product register plus one per quotient bit. The monitor samples on the falling edge and fails a result that arrives in any other cycle. It also fails a strobe that arrives with no result pending, which is how a first-sample output or a missing gap would show. Both variants take the same stimulus, and the queues must be empty once the pipeline has drained.

// File: rtl/dphase_conj.sv
module dphase_conj #(
  parameter int W    = 12,
  parameter int NORM = 1,
  parameter int FRAC = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic signed [W-1:0]   in_i,
  input  logic signed [W-1:0]   in_q,
  output logic                  out_valid,
  output logic signed [2*W:0]   out_re,
  output logic signed [2*W:0]   out_im,
  output logic                  zero_pwr
);
  localparam int MW = 2*W;
  localparam int OW = MW+1;
  localparam int QW = OW-1;
  localparam int CW = MW+QW;

  logic signed [W-1:0] prev_i, prev_q;
  logic                have_prev;

  wire signed [MW-1:0] m_ii = MW'(in_i) * MW'(prev_i);
  wire signed [MW-1:0] m_qq = MW'(in_q) * MW'(prev_q);
  wire signed [MW-1:0] m_qi = MW'(in_q) * MW'(prev_i);
  wire signed [MW-1:0] m_iq = MW'(in_i) * MW'(prev_q);
  wire signed [MW-1:0] sq_i = MW'(prev_i) * MW'(prev_i);
  wire signed [MW-1:0] sq_q = MW'(prev_q) * MW'(prev_q);

  wire signed [OW-1:0] prod_re = {m_ii[MW-1], m_ii} + {m_qq[MW-1], m_qq};
  wire signed [OW-1:0] prod_im = {m_qi[MW-1], m_qi} - {m_iq[MW-1], m_iq};
  wire        [MW-1:0] pwr_w   = $unsigned(sq_i) + $unsigned(sq_q);

  logic                p_v, p_z;
  logic signed [OW-1:0] p_re, p_im;
  logic [MW-1:0]       p_pw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_i <= '0; prev_q <= '0; have_prev <= 1'b0;
      p_v <= 1'b0; p_z <= 1'b0; p_re <= '0; p_im <= '0; p_pw <= '0;
    end else begin
      p_v <= in_valid && have_prev;
      if (in_valid) begin
        prev_i    <= in_i;
        prev_q    <= in_q;
        have_prev <= 1'b1;
        p_re      <= prod_re;
        p_im      <= prod_im;
        p_pw      <= pwr_w;
        p_z       <= (pwr_w == '0);
      end
    end
  end

  generate
    if (NORM == 0) begin : g_raw
      assign out_valid = p_v;
      assign out_re    = p_re;
      assign out_im    = p_im;
      assign zero_pwr  = p_v && p_z;
    end else begin : g_norm
      typedef struct packed {
        logic [CW-1:0] rem;
        logic [QW-1:0] q;
        logic          neg;
        logic          ovf;
      } lane_t;
      typedef struct packed {
        lane_t [1:0]   ln;
        logic [MW-1:0] pw;
        logic          v;
        logic          z;
      } stg_t;

      function automatic stg_t step(stg_t x, int b);
        stg_t y;
        logic [CW-1:0] d;
        y = x;
        d = CW'(x.pw) << b;
        for (int c = 0; c < 2; c++) begin
          if (x.ln[c].rem >= d) begin
            y.ln[c].rem  = x.ln[c].rem - d;
            y.ln[c].q[b] = 1'b1;
          end
        end
        return y;
      endfunction

      stg_t st0;
      stg_t st [1:QW];

      always_comb begin
        logic signed [OW-1:0] sel;
        logic [OW-1:0]        a;
        st0    = '0;
        st0.v  = p_v;
        st0.z  = p_z;
        st0.pw = p_pw;
        for (int c = 0; c < 2; c++) begin
          sel = (c == 0) ? p_re : p_im;
          a   = sel[OW-1] ? OW'(-sel) : OW'(sel);
          st0.ln[c].neg = sel[OW-1];
          st0.ln[c].rem = CW'(a[MW-1:0]) << FRAC;
          st0.ln[c].ovf = st0.ln[c].rem >= (CW'(p_pw) << QW);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 1; k <= QW; k++) st[k] <= '0;
        end else begin
          st[1] <= step(st0, QW-1);
          for (int k = 1; k < QW; k++) st[k+1] <= step(st[k], QW-1-k);
        end
      end

      logic signed [OW-1:0] res [2];
      always_comb begin
        logic [QW-1:0]        mag;
        logic signed [OW-1:0] val;
        for (int c = 0; c < 2; c++) begin
          mag    = st[QW].ln[c].ovf ? '1 : st[QW].ln[c].q;
          val    = $signed({1'b0, mag});
          res[c] = st[QW].z ? '0 : (st[QW].ln[c].neg ? -val : val);
        end
      end

      assign out_valid = st[QW].v;
      assign out_re    = res[0];
      assign out_im    = res[1];
      assign zero_pwr  = st[QW].v && st[QW].z;
    end
  endgenerate
endmodule

// File: rtl/dphase_conj_chk.sv
module dphase_conj_chk #(
  parameter int NORM = 1,
  parameter int OW   = 25
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_re,
  input logic signed [OW-1:0] out_im,
  input logic                 zero_pwr
);
  logic [31:0] n_in, n_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_in  <= '0;
      n_out <= '0;
    end else begin
      n_in  <= n_in + 32'(in_valid);
      n_out <= n_out + 32'(out_valid);
    end
  end

  p_first_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (n_in >= n_out + 32'd2));

  p_zero_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_pwr |-> (out_re == '0 && out_im == '0));

  p_flag_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_pwr |-> out_valid);

  generate
    if (NORM == 0) begin : g_raw_chk
      p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    end else begin : g_norm_chk
      p_sym_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_re != {1'b1, {(OW-1){1'b0}}} && out_im != {1'b1, {(OW-1){1'b0}}}));
    end
  endgenerate
endmodule

bind dphase_conj dphase_conj_chk #(.NORM(NORM), .OW(2*W+1)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_re(out_re), .out_im(out_im), .zero_pwr(zero_pwr)
);

// File: tb/dphase_conj_tb.sv
module dphase_conj_tb;
  localparam int W    = 12;
  localparam int FRAC = 14;
  localparam int OW   = 2*W+1;
  localparam int QW   = OW-1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_i = '0, in_q = '0;
  logic v0, z0, v1, z1;
  logic signed [OW-1:0] re0, im0, re1, im1;

  always #4 clk = ~clk;

  dphase_conj #(.W(W), .NORM(0), .FRAC(FRAC)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(v0), .out_re(re0), .out_im(im0), .zero_pwr(z0));

  dphase_conj #(.W(W), .NORM(1), .FRAC(FRAC)) u_dut_norm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(v1), .out_re(re1), .out_im(im1), .zero_pwr(z1));

  typedef struct {
    longint re;
    longint im;
    bit     z;
    int     due;
    string  tag;
  } exp_t;

  exp_t q0[$];
  exp_t q1[$];
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  longint mi = 0, mq = 0;
  bit mh = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint nrm(longint x, longint pw);
    longint a, qv;
    a  = (x < 0) ? -x : x;
    qv = (a <<< FRAC) / pw;
    if (qv > (64'sd1 <<< QW) - 1) qv = (64'sd1 <<< QW) - 1;
    return (x < 0) ? -qv : qv;
  endfunction

  task automatic send(input int i, input int q, input string tag);
    longint re, im, pw;
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_i = W'(i);
    in_q = W'(q);
    if (mh) begin
      re = i*mi + q*mq;
      im = q*mi - i*mq;
      pw = mi*mi + mq*mq;
      e.re = re; e.im = im; e.z = (pw == 0); e.due = cyc + 1; e.tag = tag;
      q0.push_back(e);
      e.due = cyc + 1 + QW;
      if (pw == 0) begin e.re = 0; e.im = 0; end
      else begin e.re = nrm(re, pw); e.im = nrm(im, pw); end
      q1.push_back(e);
    end
    mi = i; mq = q; mh = 1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_i = W'($urandom);
      in_q = W'($urandom);
    end
  endtask

  task automatic cmp(input int d, input longint re, input longint im, input bit z, ref exp_t qq[$]);
    exp_t e;
    n_chk++;
    if (qq.size() == 0) begin
      n_fail++;
      $display("FAIL R3 dut%0d: unexpected output re=%0d im=%0d at cyc %0d, expected no output", d, re, im, cyc);
    end else begin
      e = qq.pop_front();
      if (re != e.re || im != e.im || z != e.z || cyc != e.due) begin
        n_fail++;
        $display("FAIL %s dut%0d: re=%0d im=%0d z=%0b cyc=%0d expected re=%0d im=%0d z=%0b cyc=%0d",
                 e.tag, d, re, im, z, cyc, e.re, e.im, e.z, e.due);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (v0) cmp(0, re0, im0, z0, q0);
      if (v1) cmp(1, re1, im1, z1, q1);
    end
  end

  task automatic reset_check(input string tag);
    n_chk++;
    if (v0 !== 1'b0 || v1 !== 1'b0 || z0 !== 1'b0 || z1 !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: valid=%b/%b flag=%b/%b after reset, expected 0", tag, v0, v1, z0, z1);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    reset_check("R3 reset state");
    rst_n = 1'b1;
    mh = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R3: first sample silent for both variants; checked by the monitor
    send(1000, 0, "R3");
    idle(30);
    n_chk++;
    if (q0.size() != 0 || q1.size() != 0) begin
      n_fail++;
      $display("FAIL R3: queue sizes %0d/%0d, expected 0/0", q0.size(), q1.size());
    end
    // R1 R2 R6: quarter turn with constant amplitude
    send(0, 1000, "R2 quarter turn");
    // R2: step across the negative real axis
    send(-2047, 5, "R2 wrap pre");
    send(-2047, -5, "R2 wrap across axis");
    // R1 R5 R6: back-to-back rotation
    for (int k = 0; k < 16; k++)
      send(int'($rtoi(1800.0*$cos(0.4*k))), int'($rtoi(1800.0*$sin(0.4*k))), "R1 rotation");
    // R4: gaps carrying garbage on the data inputs
    send(300, -700, "R4 before gap");
    idle(7);
    send(-500, 200, "R4 after gap");
    idle(3);
    send(1, 1, "R4 after short gap");
    // R7: zero-power previous sample, then zero current sample
    send(0, 0, "R7 zero current");
    send(700, -300, "R7 zero previous");
    // R8: clamp in both directions
    send(1, 0, "R8 small prev");
    send(-2048, 1500, "R8 clamp");
    send(2047, -2048, "R6 large drop");
    // R1: extreme codes
    send(-2048, -2048, "R1 extremes");
    send(-2048, -2048, "R1 extremes");
    send(-2048, 2047, "R2 extremes");
    // R6: varying envelope
    for (int k = 0; k < 40; k++)
      send($urandom_range(0, 4095) - 2048, $urandom_range(0, 4095) - 2048, "R6 random");
    idle(40);
    // R3: reset mid-stream clears history
    send(900, 900, "R3 before reset");
    idle(40);
    do_reset();
    send(-1200, 400, "R3 after reset");
    send(400, 1200, "R3 second after reset");
    idle(40);
    n_chk++;
    if (q0.size() != 0 || q1.size() != 0) begin
      n_fail++;
      $display("FAIL R5 R6: missing outputs %0d/%0d, expected 0/0", q0.size(), q1.size());
    end
    finish_run();
  end
endmodule